// File: doc/BRIEF.md
# Clock Frequency Meter

This block measures how fast one of four monitored clocks runs relative to a reference clock. Software programs a window length, expressed in cycles of the monitored clock, and a channel number. It then sets an enable bit. The meter waits for a rising edge of the chosen clock. From that edge it counts reference-clock cycles until the chosen clock has completed the programmed number of further cycles. It then stores the count and raises a sticky valid flag. Software divides the window by the count to obtain the frequency ratio.

The monitored clocks arrive asynchronously. Each one passes through a two-flop synchronizer into the reference domain, where its rising edges are detected. A separate run-gate bit must be set before a measurement can progress. Clearing that bit pauses everything. All access goes through a plain single-cycle register port. Writes are taken on the clock edge, and read data is a combinational decode of the address. Because no data stream crosses the block's edge, there is no valid/ready handshake and no back-pressure.

Top module: `clk_freq_meter`

## Requirements
- R1: The control register at offset 0x00 holds the window length in bits [23:0], the enable in bit 24 and the channel number in bits [27:26]. These fields read back as written, and every other bit reads 0.
- R2: The status register at offset 0x10 has a read/write run-gate bit 8 and a read-only valid flag in bit 0. Writes to bit 0 have no effect. The count reads at offset 0x0C. Any other offset reads 0.
- R3: A completed measurement of window N on a clock of period P reference cycles reports N*P. This is the number of reference cycles from a synchronized rising edge of the monitored clock to the N-th rising edge after it.
- R4: The channel number selects monitored clock 0 to 3. It is captured when a measurement is armed, so changing it during the measurement has no effect on the result.
- R5: A 0-to-1 change of the enable bit clears the valid flag and the count to 0 and starts a new measurement. Rewriting the enable as 1 while it is already 1 does not restart the measurement.
- R6: Clearing the enable before completion abandons the measurement. The valid flag stays 0 and the count stays 0.
- R7: After completion, the valid flag and the count hold until the next 0-to-1 change of the enable, including while the enable is 0.
- R8: While the run gate is 0, the measurement makes no progress and the valid flag cannot become set. Setting the gate lets the measurement proceed.
- R9: The count saturates at all ones (2^RES_W-1) instead of wrapping.
- R10: After reset, the control, status and count registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_clk | input | NUM_CH | Monitored clocks, asynchronous to clk |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wen | input | 1 | Write strobe, taken on the rising clk edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |

## Verification
The checker observes several behaviours on every cycle. Arming always clears the flag and the count. A set flag never drops or lets the count move without a re-arm. A closed run gate freezes the count and the flag. A saturated count stays saturated. A clear flag always comes with a zero count.

Other behaviours show only in the bench's scenarios. These are the exact N*P results on each channel and the capture of the channel at arm time. They also include abandonment through the enable, the reaction to a rewritten enable, saturation at the port, and the register field layout and read-only bits.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_COUNT  = 'h0C;
  localparam int OFF_STATUS = 'h10;

  localparam int CTRL_WIN_LSB = 0;
  localparam int CTRL_EN_BIT  = 24;
  localparam int CTRL_CH_LSB  = 26;
  localparam int STAT_VLD_BIT = 0;
  localparam int STAT_RUN_BIT = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } meter_state_e;
endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] async_clk,
  output logic [NUM_CH-1:0] rise
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [2:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= '0;
      else        stage <= {stage[1:0], async_clk[g]};
    end
    assign rise[g] = stage[1] & ~stage[2];
  end
endmodule

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int WIN_W  = 24,
  parameter int SEL_W  = 2,
  parameter int RES_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [WIN_W-1:0]  win_o,
  output logic              en_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              run_o,
  input  logic              valid_i,
  input  logic [RES_W-1:0]  count_i
);
  logic wr_ctrl, wr_stat;
  logic unused_wbits;

  assign wr_ctrl = bus_wen && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = bus_wen && (bus_addr == ADDR_W'(OFF_STATUS));
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_o <= '0;
      en_o  <= 1'b0;
      sel_o <= '0;
      run_o <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        win_o <= bus_wdata[CTRL_WIN_LSB +: WIN_W];
        en_o  <= bus_wdata[CTRL_EN_BIT];
        sel_o <= bus_wdata[CTRL_CH_LSB +: SEL_W];
      end
      if (wr_stat) run_o <= bus_wdata[STAT_RUN_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) begin
      bus_rdata[CTRL_WIN_LSB +: WIN_W] = win_o;
      bus_rdata[CTRL_EN_BIT]           = en_o;
      bus_rdata[CTRL_CH_LSB +: SEL_W]  = sel_o;
    end else if (bus_addr == ADDR_W'(OFF_STATUS)) begin
      bus_rdata[STAT_RUN_BIT] = run_o;
      bus_rdata[STAT_VLD_BIT] = valid_i;
    end else if (bus_addr == ADDR_W'(OFF_COUNT)) begin
      bus_rdata[RES_W-1:0] = count_i;
    end
  end
endmodule

// File: rtl/fm_engine.sv
module fm_engine
  import fm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WIN_W  = 24,
  parameter int RES_W  = 32,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              run_en,
  input  logic [WIN_W-1:0]  window,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_CH-1:0] rise,
  output logic              start,
  output logic              valid,
  output logic [RES_W-1:0]  result,
  output logic [RES_W-1:0]  ref_cnt
);
  localparam logic [RES_W-1:0] CNT_MAX = '1;

  meter_state_e      state;
  logic              en_q;
  logic [SEL_W-1:0]  ch_q;
  logic [WIN_W-1:0]  edges;
  logic [WIN_W-1:0]  edges_nxt;
  logic [RES_W-1:0]  ref_inc;
  logic              pulse;

  assign start     = enable & ~en_q;
  assign pulse     = rise[ch_q];
  assign edges_nxt = edges + 1'b1;
  assign ref_inc   = (ref_cnt == CNT_MAX) ? CNT_MAX : ref_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      en_q    <= 1'b0;
      ch_q    <= '0;
      edges   <= '0;
      ref_cnt <= '0;
      valid   <= 1'b0;
      result  <= '0;
    end else begin
      en_q <= enable;
      if (start) begin
        state   <= ST_ALIGN;
        ch_q    <= sel;
        edges   <= '0;
        ref_cnt <= '0;
        valid   <= 1'b0;
        result  <= '0;
      end else if (!enable) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_ALIGN: if (run_en && pulse) begin
            state   <= ST_COUNT;
            edges   <= '0;
            ref_cnt <= '0;
          end
          ST_COUNT: if (run_en) begin
            ref_cnt <= ref_inc;
            if (pulse) begin
              edges <= edges_nxt;
              if (edges_nxt == window) begin
                result <= ref_inc;
                valid  <= 1'b1;
                state  <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int WIN_W  = 24,
  parameter int RES_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] mon_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic [WIN_W-1:0]  win;
  logic              en;
  logic [SEL_W-1:0]  sel;
  logic              run_en;
  logic [NUM_CH-1:0] rise;
  logic              start;
  logic              meas_valid;
  logic [RES_W-1:0]  meas_result;
  logic [RES_W-1:0]  ref_cnt;

  fm_edge_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_clk(mon_clk), .rise(rise)
  );

  fm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .SEL_W(SEL_W), .RES_W(RES_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .win_o(win), .en_o(en),
    .sel_o(sel), .run_o(run_en), .valid_i(meas_valid), .count_i(meas_result)
  );

  fm_engine #(.NUM_CH(NUM_CH), .WIN_W(WIN_W), .RES_W(RES_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .enable(en), .run_en(run_en), .window(win),
    .sel(sel), .rise(rise), .start(start), .valid(meas_valid),
    .result(meas_result), .ref_cnt(ref_cnt)
  );
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             run_en,
  input logic             valid,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] ref_cnt
);
  localparam logic [RES_W-1:0] CNT_MAX = '1;

  p_clear_on_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!valid && result == '0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start) |=> (valid && $stable(result)));

  p_gate_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !start) |=> ($stable(valid) && $stable(ref_cnt)));

  p_set_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(run_en));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cnt == CNT_MAX && !start) |=> ref_cnt == CNT_MAX);

  p_zero_until_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> result == '0);
endmodule

bind clk_freq_meter fm_checker #(.RES_W(RES_W)) u_fm_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .run_en(run_en),
  .valid(meas_valid), .result(meas_result), .ref_cnt(ref_cnt)
);

// File: tb/clk_freq_meter_tb_top.sv
module clk_freq_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 12;
  localparam int SAT = (1 << RES_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mon_clk = 4'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_q[$];
  int per [4] = '{4, 7, 13, 23};

  clk_freq_meter #(.RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin #3; forever #(per[0]*CLK_PERIOD/2) mon_clk[0] = ~mon_clk[0]; end
  initial begin #3; forever #(per[1]*CLK_PERIOD/2) mon_clk[1] = ~mon_clk[1]; end
  initial begin #3; forever #(per[2]*CLK_PERIOD/2) mon_clk[2] = ~mon_clk[2]; end
  initial begin #3; forever #(per[3]*CLK_PERIOD/2) mon_clk[3] = ~mon_clk[3]; end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input int n, input int ch, input bit en);
    return (32'(ch) << 26) | (32'(en) << 24) | 32'(n);
  endfunction

  // driver: arms a measurement and records the expected count
  task automatic arm(input int ch, input int n);
    int e;
    e = n * per[ch];
    if (e > SAT) e = SAT;
    exp_q.push_back(e);
    wr(5'h00, ctrl_word(n, ch, 1'b0));
    wr(5'h00, ctrl_word(n, ch, 1'b1));
  endtask

  task automatic wait_valid(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(5'h10, d);
      if (d[0]) break;
    end
    chk({31'b0, d[0]}, 32'h1, {tag, " valid set"});
  endtask

  // monitor: pops the expected count and compares it with the result read out
  task automatic check_result(input string tag);
    logic [31:0] d;
    int e;
    rd(5'h0C, d);
    e = exp_q.pop_front();
    chk(d, 32'(e), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(5'h00, d); chk(d, 0, "R10 ctrl reset");
    rd(5'h10, d); chk(d, 0, "R10 status reset");
    rd(5'h0C, d); chk(d, 0, "R10 count reset");

    wr(5'h00, 32'hFEFF_FFFF);
    rd(5'h00, d); chk(d, 32'h0CFF_FFFF, "R1 ctrl field readback");
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h0000_0101);
    rd(5'h10, d); chk(d, 32'h0000_0100, "R2 valid bit not writable");
    rd(5'h04, d); chk(d, 0, "R2 unmapped offset");

    arm(0, 10); wait_valid("R3 ch0"); check_result("R3 ch0 N*P");
    arm(1, 16); wait_valid("R4 ch1"); check_result("R4 ch1 N*P");
    arm(2, 3);  wait_valid("R4 ch2"); check_result("R4 ch2 N*P");

    arm(1, 20);
    wr(5'h00, ctrl_word(20, 3, 1'b1));
    wait_valid("R4 sel change");
    check_result("R4 R5 channel captured, rewrite no restart");

    wr(5'h00, ctrl_word(20, 3, 1'b0));
    repeat (50) @(negedge clk);
    rd(5'h10, d); chk({31'b0, d[0]}, 1, "R7 valid holds with enable 0");
    rd(5'h0C, d); chk(d, 140, "R7 count holds with enable 0");
    wr(5'h00, ctrl_word(20, 3, 1'b1));
    @(negedge clk);
    rd(5'h10, d); chk({31'b0, d[0]}, 0, "R5 arm clears valid");
    rd(5'h0C, d); chk(d, 0, "R5 arm clears count");

    wr(5'h00, ctrl_word(100, 3, 1'b0));
    wr(5'h00, ctrl_word(100, 3, 1'b1));
    repeat (50) @(negedge clk);
    wr(5'h00, ctrl_word(100, 3, 1'b0));
    repeat (3000) @(negedge clk);
    rd(5'h10, d); chk({31'b0, d[0]}, 0, "R6 abandoned valid");
    rd(5'h0C, d); chk(d, 0, "R6 abandoned count");

    wr(5'h10, 32'h0);
    arm(0, 10);
    repeat (300) @(negedge clk);
    rd(5'h10, d); chk({31'b0, d[0]}, 0, "R8 gate closed no progress");
    wr(5'h10, 32'h100);
    wait_valid("R8 gate opened");
    check_result("R8 result after gate opens");

    arm(3, 200); wait_valid("R9 long window"); check_result("R9 saturated count");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule